// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block creates the three timing signals that a serial audio port needs when it is the clock master: an optional master clock, a bit clock and a word-select strobe that marks the left and right channel slots of each sample frame. Everything is derived from one kernel clock through a programmable linear divider, whose ratio is twice an 8-bit divide value plus an odd-adjust bit. A reshaping stage keeps the divided clock balanced for odd ratios by using both kernel clock edges.

With the master clock output enabled, the divided clock leaves the block as the master clock and a fixed post-divider (by 8 for 16-bit slots, by 4 for 32-bit slots) makes the bit clock, so the master clock is always 256 times the sample rate. With the master clock disabled, its pin stays low and the bit clock is taken straight from the linear divider. A slot counter then produces word select: low for the left slot, high for the right slot, each slot lasting 16 or 32 bit-clock periods.

The configuration inputs are expected to be steady while the block is enabled; software disables the block, reprograms it and enables it again. Divide values below 2 are replaced by a safe setting and flagged.

Top module: `aud_sclk_gen`

## Requirements
- R1: The linear divider ratio is N = 2*div_i + odd_i kernel cycles; with mclk_oe_i=0 the bit clock period is N kernel cycles.
- R2: For even N the divided clock is high for exactly N/2 kernel cycles and low for N/2 cycles.
- R3: For odd N the divided clock is high for N half kernel cycles and low for N half kernel cycles (both kernel clock edges are used).
- R4: With mclk_oe_i=1, mclk_o has period N with the duty of R2/R3, and bclk_o has period 8*N cycles when chan32_i=0 and 4*N cycles when chan32_i=1, with equal high and low time.
- R5: With mclk_oe_i=0, mclk_o stays low while the bit clock keeps running.
- R6: Word select is low (0) during the left slot and high (1) during the right slot; each slot holds 16 bit-clock rising edges when chan32_i=0 and 32 when chan32_i=1.
- R7: ws_o changes only while bclk_o is low, within half a kernel cycle after the bit clock falls.
- R8: While en_i=0 all clock outputs and ws_o are low and all counters are cleared; after en_i rises, bclk_o goes high at the next kernel rising edge with ws_o low (left slot first).
- R9: A div_i value below 2 makes the block run as div_i=2, odd_i=0 (N=4) and sets cfg_err_o, which stays set even after a legal value is written.
- R10: After reset all outputs, including cfg_err_o, are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low holds outputs low and clears counters |
| div_i | input | 8 | Linear divide value |
| odd_i | input | 1 | Adds one kernel cycle to the divider ratio |
| mclk_oe_i | input | 1 | Master clock output enable, also selects the post-divider path |
| chan32_i | input | 1 | Slot length select: 0 = 16 bits, 1 = 32 bits |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select: 0 left slot, 1 right slot |
| cfg_err_o | output | 1 | Sticky flag for an illegal divide value |

## Verification
The two functions that coincide are the bit clock's falling edge and the word-select slot change: on the last bit of a slot the post-divider or the linear divider drives the bit clock low in the very cycle that the slot counter wraps or crosses the half-frame point. The bench provokes this in every frame, with odd ratios where the bit clock falls on a kernel falling edge and with even ratios and the master-clock path where it falls on a rising edge. It samples every half kernel cycle and judges each word-select change by requiring the bit clock to be already low at that sample, while also counting the bit-clock rising edges between two changes.

// File: rtl/aud_sclk_pkg.sv
package aud_sclk_pkg;
   localparam int unsigned DEF_DIV_W      = 8;
   localparam int unsigned DEF_SLOT_SHORT = 16;
   localparam int unsigned DEF_SLOT_LONG  = 32;
   localparam int unsigned DEF_PDIV_SHORT = 8;
   localparam int unsigned DEF_PDIV_LONG  = 4;

   typedef enum logic {
      SLOT_LEN_SHORT = 1'b0,
      SLOT_LEN_LONG  = 1'b1
   } slot_len_e;

   function automatic bit is_even_ge2(input int unsigned v);
      return (v >= 2) && ((v % 2) == 0);
   endfunction
endpackage

// File: rtl/aud_sclk_lindiv.sv
module aud_sclk_lindiv #(
   parameter int unsigned DIV_W     = 8,
   parameter bit          DUAL_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             odd_i,
   output logic             out_o,
   output logic             start_o,
   output logic             wrap_o,
   output logic             hfall_o
);
   localparam int unsigned CW = DIV_W + 1;

   if (DIV_W < 2) begin : g_chk_w
      $error("aud_sclk_lindiv: DIV_W must be at least 2");
   end

   logic [CW-1:0] ratio;
   logic [CW-1:0] cnt;
   logic          run;
   logic          q_pos;
   logic          last;
   logic          hlast;

   // 2*div + odd is the concatenation of the two fields
   assign ratio = {div_i, odd_i};
   assign last  = (cnt == ratio - 1'b1);
   assign hlast = (cnt == {1'b0, div_i} - 1'b1);

   assign start_o = en_i && !run;
   assign wrap_o  = en_i && run && last;
   assign hfall_o = en_i && run && hlast;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         run   <= 1'b0;
         q_pos <= 1'b0;
      end else if (!en_i) begin
         cnt   <= '0;
         run   <= 1'b0;
         q_pos <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         run   <= 1'b1;
         q_pos <= 1'b1;
      end else begin
         if (last) begin
            cnt   <= '0;
            q_pos <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
            if (hlast) q_pos <= 1'b0;
         end
      end
   end

   if (DUAL_EDGE) begin : g_reshape
      logic q_neg;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n)     q_neg <= 1'b0;
         else if (!en_i) q_neg <= 1'b0;
         else            q_neg <= q_pos;
      end
      // odd ratio: stretch the high phase by half a kernel cycle
      assign out_o = q_pos | (odd_i & q_neg);
   end else begin : g_plain
      assign out_o = q_pos;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < ratio)) else $error("cnt out of range"); // R1
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!q_pos && cnt == '0)) else $error("divider active while disabled"); // R8
   AST_HIGH_START: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !run) |=> q_pos) else $error("first period did not start high"); // R8
endmodule

// File: rtl/aud_sclk_postdiv.sv
module aud_sclk_postdiv #(
   parameter int unsigned PDIV_SHORT = 8,
   parameter int unsigned PDIV_LONG  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic use_mclk_i,
   input  logic chan32_i,
   input  logic lin_i,
   input  logic start_i,
   input  logic wrap_i,
   input  logic hfall_i,
   output logic bclk_o,
   output logic bfall_o
);
   import aud_sclk_pkg::*;

   localparam int unsigned PMAX = (PDIV_SHORT > PDIV_LONG) ? PDIV_SHORT : PDIV_LONG;
   localparam int unsigned PW   = $clog2(PMAX) + 1;

   if (!is_even_ge2(PDIV_SHORT) || !is_even_ge2(PDIV_LONG)) begin : g_chk_p
      $error("aud_sclk_postdiv: post-divider ratios must be even and at least 2");
   end

   logic [PW-1:0] pdiv;
   logic [PW-1:0] phalf;
   logic [PW-1:0] p;
   logic          bq;
   logic          p_last;
   logic          p_mid;

   assign pdiv   = (slot_len_e'(chan32_i) == SLOT_LEN_LONG) ? PW'(PDIV_LONG) : PW'(PDIV_SHORT);
   assign phalf  = pdiv >> 1;
   assign p_last = (p == pdiv - 1'b1);
   assign p_mid  = (p == phalf - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p  <= '0;
         bq <= 1'b0;
      end else if (!en_i) begin
         p  <= '0;
         bq <= 1'b0;
      end else if (start_i) begin
         p  <= '0;
         bq <= 1'b1;
      end else if (wrap_i) begin
         if (p_last) begin
            p  <= '0;
            bq <= 1'b1;
         end else begin
            p <= p + 1'b1;
            if (p_mid) bq <= 1'b0;
         end
      end
   end

   assign bclk_o  = use_mclk_i ? bq : lin_i;
   assign bfall_o = use_mclk_i ? (wrap_i && p_mid) : hfall_i;

   AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      p < pdiv) else $error("post-divider count out of range"); // R4
   AST_BQ_ON_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && !$stable(bq)) |-> $past(wrap_i || start_i))
      else $error("bit clock moved between master clock periods"); // R4
endmodule

// File: rtl/aud_sclk_wsgen.sv
module aud_sclk_wsgen #(
   parameter int unsigned SLOT_SHORT = 16,
   parameter int unsigned SLOT_LONG  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic chan32_i,
   input  logic bfall_i,
   output logic ws_o
);
   import aud_sclk_pkg::*;

   localparam int unsigned SMAX = (SLOT_SHORT > SLOT_LONG) ? SLOT_SHORT : SLOT_LONG;
   localparam int unsigned BW   = $clog2(2 * SMAX) + 1;

   if (SLOT_SHORT < 1 || SLOT_LONG < 1) begin : g_chk_s
      $error("aud_sclk_wsgen: slot lengths must be at least 1");
   end

   logic [BW-1:0] slot;
   logic [BW-1:0] b;
   logic          ws_pos;
   logic          ws_neg;

   assign slot = (slot_len_e'(chan32_i) == SLOT_LEN_LONG) ? BW'(SLOT_LONG) : BW'(SLOT_SHORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b      <= '0;
         ws_pos <= 1'b0;
      end else if (!en_i) begin
         b      <= '0;
         ws_pos <= 1'b0;
      end else if (bfall_i) begin
         if (b == (slot << 1) - 1'b1) begin
            b      <= '0;
            ws_pos <= 1'b0;
         end else begin
            b <= b + 1'b1;
            if (b == slot - 1'b1) ws_pos <= 1'b1;
         end
      end
   end

   // retime onto the falling kernel edge so the change lands in the low phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)     ws_neg <= 1'b0;
      else if (!en_i) ws_neg <= 1'b0;
      else            ws_neg <= ws_pos;
   end

   assign ws_o = ws_neg;

   AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      b < (slot << 1)) else $error("slot bit count out of range"); // R6
   AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && !$stable(ws_pos)) |-> $past(bfall_i))
      else $error("word select moved without a bit clock fall"); // R7
endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen #(
   parameter int unsigned DIV_W      = aud_sclk_pkg::DEF_DIV_W,
   parameter bit          DUAL_EDGE  = 1'b1,
   parameter int unsigned SLOT_SHORT = aud_sclk_pkg::DEF_SLOT_SHORT,
   parameter int unsigned SLOT_LONG  = aud_sclk_pkg::DEF_SLOT_LONG,
   parameter int unsigned PDIV_SHORT = aud_sclk_pkg::DEF_PDIV_SHORT,
   parameter int unsigned PDIV_LONG  = aud_sclk_pkg::DEF_PDIV_LONG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             odd_i,
   input  logic             mclk_oe_i,
   input  logic             chan32_i,
   output logic             mclk_o,
   output logic             bclk_o,
   output logic             ws_o,
   output logic             cfg_err_o
);
   localparam logic [DIV_W-1:0] SAFE_DIV = DIV_W'(2);

   if (PDIV_SHORT * SLOT_SHORT != PDIV_LONG * SLOT_LONG) begin : g_chk_mclk
      $error("aud_sclk_gen: master clock ratio must match for both slot lengths");
   end

   logic             bad_div;
   logic [DIV_W-1:0] eff_div;
   logic             eff_odd;
   logic             lin_clk;
   logic             lin_start;
   logic             lin_wrap;
   logic             lin_hfall;
   logic             bit_fall;
   logic             err_q;

   assign bad_div = (div_i < SAFE_DIV);
   assign eff_div = bad_div ? SAFE_DIV : div_i;
   assign eff_odd = bad_div ? 1'b0 : odd_i;

   aud_sclk_lindiv #(.DIV_W(DIV_W), .DUAL_EDGE(DUAL_EDGE)) lindiv_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .div_i   (eff_div),
      .odd_i   (eff_odd),
      .out_o   (lin_clk),
      .start_o (lin_start),
      .wrap_o  (lin_wrap),
      .hfall_o (lin_hfall)
   );

   aud_sclk_postdiv #(.PDIV_SHORT(PDIV_SHORT), .PDIV_LONG(PDIV_LONG)) postdiv_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .use_mclk_i (mclk_oe_i),
      .chan32_i   (chan32_i),
      .lin_i      (lin_clk),
      .start_i    (lin_start),
      .wrap_i     (lin_wrap),
      .hfall_i    (lin_hfall),
      .bclk_o     (bclk_o),
      .bfall_o    (bit_fall)
   );

   aud_sclk_wsgen #(.SLOT_SHORT(SLOT_SHORT), .SLOT_LONG(SLOT_LONG)) wsgen_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .chan32_i (chan32_i),
      .bfall_i  (bit_fall),
      .ws_o     (ws_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 err_q <= 1'b0;
      else if (en_i && bad_div)   err_q <= 1'b1;
   end

   assign cfg_err_o = err_q;
   assign mclk_o    = mclk_oe_i & lin_clk;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> cfg_err_o) else $error("error flag cleared"); // R9
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && div_i < SAFE_DIV) |=> cfg_err_o) else $error("illegal divide not flagged"); // R9
endmodule

// File: tb/aud_sclk_gen_tb.sv
`timescale 1ns/100ps
module aud_sclk_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] div = 8'd2;
   logic       odd = 1'b0;
   logic       oe = 1'b0;
   logic       c32 = 1'b0;
   logic       mclk, bclk, ws, err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit mclk_seen = 1'b0;
   logic b_prev = 1'b0;
   logic w_prev = 1'b0;

   always #2.5 clk = ~clk;

   aud_sclk_gen dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .div_i(div), .odd_i(odd),
      .mclk_oe_i(oe), .chan32_i(c32), .mclk_o(mclk), .bclk_o(bclk),
      .ws_o(ws), .cfg_err_o(err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one sample per half kernel cycle, 1 ns after each edge
   task automatic half();
      b_prev = bclk;
      w_prev = ws;
      @(posedge clk or negedge clk);
      #1;
      if (mclk) mclk_seen = 1'b1;
   endtask

   task automatic cfg(input int d, input bit o, input bit m, input bit l);
      @(posedge clk); #1;
      en = 1'b0;
      @(posedge clk); #1;
      div = 8'(d); odd = o; oe = m; c32 = l;
      en = 1'b1;
      mclk_seen = 1'b0;
   endtask

   function automatic logic pick(input int sel);
      return (sel == 0) ? mclk : bclk;
   endfunction

   // high and low time of one period, counted in half kernel cycles
   task automatic meas(input int sel, output int hi, output int lo);
      int g = 0;
      hi = 0; lo = 0;
      while (pick(sel) !== 1'b0 && g < 4000) begin half(); g++; end
      while (pick(sel) !== 1'b1 && g < 4000) begin half(); g++; end
      while (pick(sel) === 1'b1 && g < 4000) begin half(); hi++; g++; end
      while (pick(sel) === 1'b0 && g < 4000) begin half(); lo++; g++; end
   endtask

   task automatic t_reset();
      chk("R10 mclk after reset", int'(mclk), 0);
      chk("R10 bclk after reset", int'(bclk), 0);
      chk("R10 ws after reset", int'(ws), 0);
      chk("R10 cfg_err after reset", int'(err), 0);
   endtask

   task automatic t_lin_even();
      int hi, lo;
      cfg(3, 0, 0, 0);
      meas(1, hi, lo);
      chk("R1 even ratio 6 period halves", hi + lo, 12);
      chk("R2 even ratio 6 high halves", hi, 6);
      cfg(10, 0, 0, 1);
      meas(1, hi, lo);
      chk("R2 even ratio 20 high halves", hi, 20);
      chk("R2 even ratio 20 low halves", lo, 20);
      chk("R5 mclk stays low with output disabled", int'(mclk_seen), 0);
   endtask

   task automatic t_lin_odd();
      int hi, lo;
      cfg(2, 1, 0, 0);
      meas(1, hi, lo);
      chk("R3 odd ratio 5 high halves", hi, 5);
      chk("R3 odd ratio 5 low halves", lo, 5);
      cfg(7, 1, 0, 0);
      meas(1, hi, lo);
      chk("R1 odd ratio 15 period halves", hi + lo, 30);
      chk("R3 odd ratio 15 high halves", hi, 15);
   endtask

   task automatic t_mclk();
      int hi, lo;
      cfg(2, 1, 1, 0);
      meas(0, hi, lo);
      chk("R4 mclk high halves ratio 5", hi, 5);
      chk("R4 mclk low halves ratio 5", lo, 5);
      meas(1, hi, lo);
      chk("R4 bclk high halves by 8", hi, 40);
      chk("R4 bclk low halves by 8", lo, 40);
      cfg(3, 0, 1, 1);
      meas(1, hi, lo);
      chk("R4 bclk high halves by 4", hi, 24);
      chk("R4 bclk low halves by 4", lo, 24);
   endtask

   // count bit clock rises per word-select level, check R7 at each change
   task automatic t_frame(input int d, input bit o, input bit m, input bit l, input int slot);
      int g = 0;
      int rises;
      cfg(d, o, m, l);
      while (!(ws === 1'b1 && w_prev === 1'b0) && g < 60000) begin half(); g++; end
      chk("R7 bclk low at ws rise", int'(bclk), 0);
      rises = 0;
      while (!(ws === 1'b0 && w_prev === 1'b1) && g < 60000) begin
         half(); g++;
         if (bclk === 1'b1 && b_prev === 1'b0) rises++;
      end
      chk("R6 right slot bit clocks", rises, slot);
      chk("R7 bclk low at ws fall", int'(bclk), 0);
      rises = 0;
      while (!(ws === 1'b1 && w_prev === 1'b0) && g < 60000) begin
         half(); g++;
         if (bclk === 1'b1 && b_prev === 1'b0) rises++;
      end
      chk("R6 left slot bit clocks", rises, slot);
   endtask

   task automatic t_enable();
      cfg(4, 1, 1, 0);
      repeat (37) @(posedge clk);
      #1;
      en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R8 bclk low while disabled", int'(bclk), 0);
      chk("R8 mclk low while disabled", int'(mclk), 0);
      chk("R8 ws low while disabled", int'(ws), 0);
      oe = 1'b0; odd = 1'b0;
      en = 1'b1;
      @(posedge clk); #1;
      chk("R8 first bclk edge after enable", int'(bclk), 1);
      chk("R8 left slot first after enable", int'(ws), 0);
   endtask

   task automatic t_bad_div();
      int hi, lo;
      cfg(1, 1, 0, 0);
      meas(1, hi, lo);
      chk("R9 fallback high halves", hi, 4);
      chk("R9 fallback low halves", lo, 4);
      chk("R9 error flag set", int'(err), 1);
      cfg(5, 0, 0, 0);
      repeat (20) @(posedge clk);
      #1;
      chk("R9 error flag sticky", int'(err), 1);
      rst_n = 1'b0;
      #7;
      chk("R10 error flag cleared by reset", int'(err), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_lin_even();
      t_lin_odd();
      t_mclk();
      t_frame(2, 0, 0, 0, 16);
      t_frame(3, 1, 0, 1, 32);
      t_frame(2, 1, 1, 0, 16);
      t_frame(2, 0, 1, 1, 32);
      t_enable();
      t_bad_div();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule